// File: doc/BRIEF.md
# Clock-Stop Serial Port Master

This block is a synchronous serial master that shifts a parallel word out on a data line while it shifts a word in. Its serial clock is a divided copy of the system clock. The divider makes one half-period last `clk_div + 1` system cycles. An active-low frame select marks each word and serves as the slave select of an SPI-style link. A 2-bit clock-stop field picks between two behaviours. In the first, the serial clock runs all the time. In the second, the clock is silent between words and starts either at once or after an extra half-period.

The receive side can take its clock, frame and data from external pins. It can instead use the transmit side's own clock, frame and data without leaving the block. In clock-stop mode the receive clock and receive frame always come from the transmit side. A loopback enable also takes the receive data from the transmit data, so the port receives exactly what it sends.

The port is driven by a one-cycle `start` pulse with the word on `tx_word`. `busy` stays high for the whole frame. A one-cycle `done` marks valid data on `rx_word`. Configuration inputs are captured when a transfer is accepted and held until `busy` falls.

Top module: `csp_master`

## Requirements
- R1: After reset, `ssel_n` is 1, `sclk` is 0, `sdata_out` is 0, and `busy`, `done` and `rx_word` are 0.
- R2: With `stop_mode` = 2'b10, an accepted start makes `busy` 1 and `ssel_n` 0 on the next cycle. The first `sclk` edge comes one half-period (`clk_div+1` cycles) later. `busy` lasts (2·WORD_W+1)·(`clk_div`+1) cycles, and `ssel_n` is low only while `busy` is 1.
- R3: With `stop_mode` = 2'b11, the first `sclk` edge comes two half-periods after `ssel_n` falls, and `busy` lasts (2·WORD_W+2)·(`clk_div`+1) cycles.
- R4: In clock-stop mode (`stop_mode[1]`=1), `sclk` rests at the level of `tx_pol` and does not toggle while `busy` is 0.
- R5: `tx_pol`=0 gives an idle-low clock whose first edge rises. `tx_pol`=1 gives an idle-high clock whose first edge falls.
- R6: The word leaves MSB first. The first bit is on `sdata_out` when `ssel_n` falls. Each following bit changes on a trailing (even-numbered) edge, so the bit is stable at every leading edge.
- R7: With `loop_en`=1 and `rx_edge` equal to `tx_pol`, `rx_word` equals the transmitted word. `done` is a one-cycle pulse, one cycle after `busy` falls.
- R8: `rx_edge`=0 samples receive data on rising receive-clock edges and `rx_edge`=1 on falling ones. In loopback with `rx_edge` not equal to `tx_pol`, sampling falls on trailing edges and `rx_word` = {tx_word[WORD_W-2:0], 0}.
- R9: In clock-stop mode with `loop_en`=0, the receive clock and frame come from the transmit side and the data from `sdata_in`.
- R10: With `stop_mode` = 2'b0X, `sclk` toggles every `clk_div+1` cycles even while idle.
- R11: With `stop_mode` = 2'b0X and `loop_en`=0, the receive path uses `sclk_in`/`ssel_in_n`/`sdata_in`. The internal clock is ignored, so with a silent external clock `rx_word` keeps its previous value.
- R12: A `start` pulse while `busy` is 1 is ignored. The frame length does not change and only one `done` follows.
- R13: With `stop_mode` = 2'b0X and `loop_en`=1, the frame begins on a clock half-period that returns `sclk` to idle, and the port receives the word it sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transfer request |
| tx_word | input | WORD_W | Word to send |
| clk_div | input | DIV_W | Half-period length minus one, in system cycles |
| stop_mode | input | 2 | 0X continuous clock, 10 clock-stop, 11 clock-stop with half-period delay |
| tx_pol | input | 1 | Idle level of sclk; 0 means first edge rises |
| rx_edge | input | 1 | 0 samples on rising receive-clock edges, 1 on falling |
| loop_en | input | 1 | Feed receive data, frame and clock from the transmit side |
| sclk_in | input | 1 | External receive clock |
| ssel_in_n | input | 1 | External receive frame, active low |
| sdata_in | input | 1 | External receive data |
| sclk | output | 1 | Serial clock |
| ssel_n | output | 1 | Frame select, active low |
| sdata_out | output | 1 | Serial transmit data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse, rx_word valid |
| rx_word | output | WORD_W | Received word |

## Verification
If the sequencer state is wrong, the frame length on `busy` or the position of the first `sclk` edge after `ssel_n` falls will be off. Both show up within the first or last half-period of the frame. If the shift register or the edge counter is wrong, a bit comes out misplaced at a leading edge. A port-side capture catches this in the same half-period, and the loopback word compared on `done` catches it at the end of the frame. If the receive source selection is wrong, the word arriving with `done` differs from the expected one: a silent external clock gives an unchanged word, and the responder gives inverted data.

// File: rtl/csp_pkg.sv
`timescale 1ns/1ps
package csp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL
  } xfer_st_t;

  typedef struct packed {
    logic [1:0] stop_mode;
    logic       tx_pol;
    logic       rx_edge;
    logic       loop_en;
  } port_cfg_t;
endpackage

// File: rtl/csp_halfper_tick.sv
`timescale 1ns/1ps
module csp_halfper_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == div);
endmodule

// File: rtl/csp_tx_engine.sv
`timescale 1ns/1ps
module csp_tx_engine
  import csp_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tick,
  input  port_cfg_t         cfg_live,
  input  logic [WORD_W-1:0] tx_word,
  output port_cfg_t         cfg_act,
  output logic              run,
  output logic              sclk,
  output logic              ssel_n,
  output logic              sdout,
  output logic              busy,
  output logic              fin
);
  localparam int EDGE_W = $clog2(2*WORD_W + 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2*WORD_W - 1);

  xfer_st_t          st;
  port_cfg_t         cfg_q;
  logic [WORD_W-1:0] shreg;
  logic [EDGE_W-1:0] edge_cnt;
  logic              lead_left;
  logic              stop;
  logic              accept;

  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= '0;
    else if (!busy) cfg_q <= cfg_live;
  end

  assign cfg_act = busy ? cfg_q : cfg_live;
  assign stop    = cfg_act.stop_mode[1];
  assign accept  = start && !busy;
  assign run     = busy || !stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      sclk      <= 1'b0;
      ssel_n    <= 1'b1;
      sdout     <= 1'b0;
      busy      <= 1'b0;
      fin       <= 1'b0;
      shreg     <= '0;
      edge_cnt  <= '0;
      lead_left <= 1'b0;
    end else begin
      fin <= 1'b0;
      // continuous clocking outside clock-stop mode
      if (!stop && tick) sclk <= ~sclk;
      case (st)
        ST_IDLE: begin
          if (stop) sclk <= cfg_act.tx_pol;
          if (accept) begin
            busy     <= 1'b1;
            shreg    <= tx_word;
            edge_cnt <= '0;
            if (stop) begin
              ssel_n    <= 1'b0;
              sdout     <= tx_word[WORD_W-1];
              lead_left <= cfg_act.stop_mode[0];
              st        <= ST_LEAD;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          // frame opens on the half-period that returns sclk to idle
          if (tick && (sclk != cfg_act.tx_pol)) begin
            ssel_n    <= 1'b0;
            sdout     <= shreg[WORD_W-1];
            lead_left <= 1'b0;
            st        <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            if (lead_left) begin
              lead_left <= 1'b0;
            end else begin
              sclk     <= ~sclk;
              edge_cnt <= EDGE_W'(1);
              st       <= ST_SHIFT;
            end
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk     <= ~sclk;
            edge_cnt <= edge_cnt + 1'b1;
            if (edge_cnt[0]) begin
              shreg <= {shreg[WORD_W-2:0], 1'b0};
              sdout <= shreg[WORD_W-2];
            end
            if (edge_cnt == LAST_EDGE) st <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            ssel_n <= 1'b1;
            busy   <= 1'b0;
            fin    <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csp_rx_path.sv
`timescale 1ns/1ps
module csp_rx_path
  import csp_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  port_cfg_t         cfg_act,
  input  logic              sclk,
  input  logic              ssel_n,
  input  logic              sdout,
  input  logic              sclk_in,
  input  logic              ssel_in_n,
  input  logic              sdata_in,
  input  logic              fin,
  output logic [WORD_W-1:0] rx_word,
  output logic              done
);
  logic [SYNC_N-1:0] s_clk, s_fs, s_dat;
  logic              internal, rclk, rfs_n, rdat, rclk_q, take;
  logic [WORD_W-1:0] rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_clk <= '0;
      s_fs  <= '1;
      s_dat <= '0;
    end else begin
      s_clk <= {s_clk[SYNC_N-2:0], sclk_in};
      s_fs  <= {s_fs[SYNC_N-2:0], ssel_in_n};
      s_dat <= {s_dat[SYNC_N-2:0], sdata_in};
    end
  end

  assign internal = cfg_act.stop_mode[1] | cfg_act.loop_en;
  assign rclk     = internal ? sclk : s_clk[SYNC_N-1];
  assign rfs_n    = internal ? ssel_n : s_fs[SYNC_N-1];
  assign rdat     = cfg_act.loop_en ? sdout : s_dat[SYNC_N-1];
  assign take     = !rfs_n && (cfg_act.rx_edge ? (rclk_q && !rclk)
                                              : (!rclk_q && rclk));

  always_ff @(posedge clk) begin
    if (rst) begin
      rclk_q  <= 1'b0;
      rx_sh   <= '0;
      rx_word <= '0;
      done    <= 1'b0;
    end else begin
      rclk_q <= rclk;
      if (take) rx_sh <= {rx_sh[WORD_W-2:0], rdat};
      done <= fin;
      if (fin) rx_word <= rx_sh;
    end
  end
endmodule

// File: rtl/csp_master.sv
`timescale 1ns/1ps
module csp_master
  import csp_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [1:0]        stop_mode,
  input  logic              tx_pol,
  input  logic              rx_edge,
  input  logic              loop_en,
  input  logic              sclk_in,
  input  logic              ssel_in_n,
  input  logic              sdata_in,
  output logic              sclk,
  output logic              ssel_n,
  output logic              sdata_out,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  port_cfg_t cfg_live, cfg_act;
  logic      run, tick, fin;

  assign cfg_live = '{stop_mode: stop_mode, tx_pol: tx_pol,
                      rx_edge: rx_edge, loop_en: loop_en};

  csp_halfper_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(run), .div(clk_div), .tick(tick)
  );

  csp_tx_engine #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst(rst), .start(start), .tick(tick),
    .cfg_live(cfg_live), .tx_word(tx_word), .cfg_act(cfg_act), .run(run),
    .sclk(sclk), .ssel_n(ssel_n), .sdout(sdata_out), .busy(busy), .fin(fin)
  );

  csp_rx_path #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .cfg_act(cfg_act), .sclk(sclk), .ssel_n(ssel_n),
    .sdout(sdata_out), .sclk_in(sclk_in), .ssel_in_n(ssel_in_n),
    .sdata_in(sdata_in), .fin(fin), .rx_word(rx_word), .done(done)
  );
endmodule

// File: rtl/csp_master_chk.sv
`timescale 1ns/1ps
module csp_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [1:0] stop_mode,
  input logic       tx_pol,
  input logic       sclk,
  input logic       ssel_n,
  input logic       busy,
  input logic       done
);
  logic pv1, pv2;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv1 <= 1'b0;
      pv2 <= 1'b0;
    end else begin
      pv1 <= 1'b1;
      pv2 <= pv1;
    end
  end

  // R2
  frame_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !ssel_n |-> busy);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && stop_mode[1]) |=> (busy && !ssel_n));

  // R2
  frame_close_chk: assert property (@(posedge clk) disable iff (rst)
    (pv1 && $rose(ssel_n)) |-> ($past(busy) && !busy));

  // R4
  idle_clk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pv1 && $past(!busy && stop_mode[1]) && !busy) |-> (sclk == $past(tx_pol)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (pv2 && done) |-> (!busy && $past(busy, 2)));
endmodule

bind csp_master csp_master_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .stop_mode(stop_mode),
  .tx_pol(tx_pol), .sclk(sclk), .ssel_n(ssel_n), .busy(busy), .done(done)
);

// File: tb/csp_master_tb.sv
`timescale 1ns/1ps
module csp_master_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] tx_word = '0;
  logic [7:0]   clk_div = 8'd1;
  logic [1:0]   stop_mode = 2'b10;
  logic         tx_pol = 1'b0, rx_edge = 1'b0, loop_en = 1'b1;
  logic         inv_resp = 1'b0;
  logic         sclk, ssel_n, sdata_out, busy, done, sdata_in;
  logic [W-1:0] rx_word;

  int tests = 0, fails = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] txexp = '0;
  logic [W-1:0] cap = '0;
  int           ncap = 0;
  logic         sclk_prev = 1'b0, ssel_prev = 1'b1;
  bit           ended = 1'b0;

  assign sdata_in = inv_resp ? ~sdata_out : 1'b0;

  always #2 clk = ~clk;

  csp_master #(.WORD_W(W), .DIV_W(8)) u_dut (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_word), .clk_div(clk_div),
    .stop_mode(stop_mode), .tx_pol(tx_pol), .rx_edge(rx_edge), .loop_en(loop_en),
    .sclk_in(1'b0), .ssel_in_n(1'b1), .sdata_in(sdata_in),
    .sclk(sclk), .ssel_n(ssel_n), .sdata_out(sdata_out), .busy(busy),
    .done(done), .rx_word(rx_word)
  );

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: received words
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) check_eq("R12 unexpected done", 32'd1, 32'd0);
      else check_eq(tag_q.pop_front(), 32'(rx_word), 32'(exp_q.pop_front()));
    end
  end

  // transmit bit capture at leading edges (R6)
  always @(negedge clk) begin
    if (!rst) begin
      if (ssel_prev && !ssel_n) begin
        cap  = '0;
        ncap = 0;
      end
      if (!ssel_n && (sclk != sclk_prev) && (sclk != tx_pol)) begin
        cap = {cap[W-2:0], sdata_out};
        ncap++;
      end
      if (!ssel_prev && ssel_n)
        check_eq("R6 serial bits MSB first", {16'(ncap), 8'h0, cap}, {16'(W), 8'h0, txexp});
    end
    sclk_prev = sclk;
    ssel_prev = ssel_n;
  end

  task automatic run_xfer(input logic [W-1:0] w, input logic [W-1:0] exp_rx,
                          input string tag, input bit extra,
                          output int blen, output int fedge, output logic fval);
    logic idle0;
    exp_q.push_back(exp_rx);
    tag_q.push_back(tag);
    txexp = w;
    @(negedge clk);
    tx_word = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    blen = 0;
    fedge = -1;
    fval = 1'b0;
    idle0 = sclk;
    while (busy) begin
      if (fedge < 0 && sclk != idle0) begin
        fedge = blen;
        fval = sclk;
      end
      if (extra && blen == 5) begin
        start = 1'b1;
        tx_word = 8'hFF;
      end else begin
        start = 1'b0;
      end
      blen++;
      @(negedge clk);
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic count_toggles(input int n, output int t);
    logic p;
    t = 0;
    @(negedge clk);
    p = sclk;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sclk != p) t++;
      p = sclk;
    end
  endtask

  initial begin
    int bl, fe, tg;
    logic fv;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 ssel_n", 32'(ssel_n), 32'd1);
    check_eq("R1 sclk", 32'(sclk), 32'd0);
    check_eq("R1 sdata_out", 32'(sdata_out), 32'd0);
    check_eq("R1 busy/done", {30'd0, busy, done}, 32'd0);
    check_eq("R1 rx_word", 32'(rx_word), 32'd0);

    // R2 / R7: mode 10, loopback, divider 1
    run_xfer(8'hA5, 8'hA5, "R7 loopback word", 1'b0, bl, fe, fv);
    check_eq("R2 busy length div1", 32'(bl), 32'((2*W+1)*2));
    check_eq("R2 first edge div1", 32'(fe), 32'd2);
    check_eq("R5 first edge rises", 32'(fv), 32'd1);

    // R2 with divider 0
    clk_div = 8'd0;
    run_xfer(8'h3C, 8'h3C, "R7 loopback word div0", 1'b0, bl, fe, fv);
    check_eq("R2 busy length div0", 32'(bl), 32'(2*W+1));
    check_eq("R2 first edge div0", 32'(fe), 32'd1);

    // R3 delayed start
    clk_div = 8'd1;
    stop_mode = 2'b11;
    run_xfer(8'h96, 8'h96, "R3 loopback word delayed", 1'b0, bl, fe, fv);
    check_eq("R3 busy length", 32'(bl), 32'((2*W+2)*2));
    check_eq("R3 first edge", 32'(fe), 32'd4);

    // R4 / R5 idle high clock held still
    stop_mode = 2'b10;
    tx_pol = 1'b1;
    rx_edge = 1'b1;
    repeat (3) @(negedge clk);
    count_toggles(20, tg);
    check_eq("R4 idle toggles", 32'(tg), 32'd0);
    check_eq("R4 idle level", 32'(sclk), 32'd1);
    run_xfer(8'hC3, 8'hC3, "R5 loopback word pol1", 1'b0, bl, fe, fv);
    check_eq("R5 first edge falls", 32'(fv), 32'd0);

    // R8 mismatched sampling edge
    tx_pol = 1'b0;
    rx_edge = 1'b1;
    repeat (3) @(negedge clk);
    run_xfer(8'hB7, 8'h6E, "R8 trailing-edge sampling", 1'b0, bl, fe, fv);

    // R9 external data, internal clock and frame
    rx_edge = 1'b0;
    loop_en = 1'b0;
    inv_resp = 1'b1;
    clk_div = 8'd3;
    run_xfer(8'h5A, 8'hA5, "R9 external data word", 1'b0, bl, fe, fv);

    // R12 start during busy ignored
    inv_resp = 1'b0;
    loop_en = 1'b1;
    clk_div = 8'd1;
    run_xfer(8'h81, 8'h81, "R12 word after ignored start", 1'b1, bl, fe, fv);
    check_eq("R12 busy length", 32'(bl), 32'((2*W+1)*2));

    // R10 continuous clock
    stop_mode = 2'b00;
    loop_en = 1'b0;
    repeat (3) @(negedge clk);
    count_toggles(40, tg);
    check_eq("R10 free-running toggles", 32'(tg), 32'd20);

    // R13 continuous clock, loopback, 0X encoding with low bit set
    stop_mode = 2'b01;
    loop_en = 1'b1;
    run_xfer(8'h4D, 8'h4D, "R13 continuous loopback word", 1'b0, bl, fe, fv);

    // R11 external receive clock silent: word unchanged
    stop_mode = 2'b00;
    loop_en = 1'b0;
    run_xfer(8'h11, 8'h4D, "R11 internal clock ignored", 1'b0, bl, fe, fv);

    repeat (5) @(negedge clk);
    check_eq("R12 all done pulses seen", 32'(exp_q.size()), 32'd0);
    ended = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule